// File: doc/BRIEF.md
# ATAPI Packet Command PIO Read Sequencer

This block is the device side of a packet-command read carried out in programmed I/O. The host first loads a transfer size cap into the two byte-count registers. It then writes the packet opcode into the command register. The sequencer opens a window for a 12-byte command packet, which arrives as six 16-bit words. It decodes that packet as a 10-byte-form block read. It then streams 2048-byte blocks out of a small internal block store, in bursts that never exceed the cap.

Each burst is announced by an interrupt. While a burst is pending, the byte-count registers report its exact length. One more interrupt marks the end of the command. A status read clears a pending interrupt. An opcode the block cannot serve ends the command at once with the error bit set.

Host register accesses are plain strobes with a combinational read path. Data moves through two streams. Packet words enter on `pkt_*`. A word transfers on a cycle where `pkt_valid` and `pkt_ready` are both high, and `pkt_ready` is high only while the packet window is open and not yet full. Read data leaves on `dout_*`. Once `dout_valid` rises, it stays high with `dout_data` unchanged until the host takes the word with `dout_ready`. The host may hold off for any number of cycles.

Top module: `atapi_pio_seq`

## Requirements
- R1: After reset the status register (address 7) reads 0x40: bit 6 ready set; bit 7 busy, bit 5 fault, bit 3 data request and bit 0 error all clear. `intrq`, `pkt_ready` and `dout_valid` are low.
- R2: Writing 0xA0 to address 7 while idle opens the packet window, and status then reads 0x48 with `pkt_ready` high. Any other command byte is ignored: status stays 0x40, no interrupt is raised, and `pkt_ready` stays low.
- R3: Exactly six packet words are accepted. Word i carries packet byte 2i in bits 7:0 and byte 2i+1 in bits 15:8. `pkt_ready` is low once the sixth word is taken.
- R4: A packet whose byte 0 is 0x28 is a read. Bytes 2..5 form a big-endian start block and bytes 7..8 form a big-endian block count. The n-th word returned (n from 0) is ((lba + n/1024) mod 2^BLK_AW) * 1024 + (n mod 1024).
- R5: The burst cap is taken at command time from address 4 (low byte) and address 5 (high byte). An odd cap is rounded down to even, and a cap below 2 is used as 2.
- R6: Each burst carries min(cap, bytes remaining) bytes. While the burst is pending, that byte count is readable at addresses 4 (low) and 5 (high).
- R7: Before each burst `intrq` rises, and status reads 0x48.
- R8: Reading the status register clears a pending interrupt.
- R9: After the last word, one completion interrupt is raised, and status then reads 0x40.
- R10: A read with a block count of zero transfers no data and goes straight to the completion interrupt, with status 0x40.
- R11: A packet opcode other than 0x28 ends the command with status 0x41 (data request clear) and a completion interrupt. The next accepted packet command clears the error bit.
- R12: While `dout_valid` is high and `dout_ready` is low, `dout_valid` stays high and `dout_data` is unchanged.
- R13: Busy (0xC0 with ready) is shown from the cycle after the sixth packet word until the first burst opens, and busy never appears together with data request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (a status read clears the interrupt) |
| reg_addr | input | 3 | Register address: 4 and 5 byte count, 7 command/status |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| pkt_valid | input | 1 | Packet word valid |
| pkt_ready | output | 1 | Packet word ready |
| pkt_data | input | 16 | Packet word |
| dout_valid | output | 1 | Read data word valid |
| dout_ready | input | 1 | Read data word taken |
| dout_data | output | 16 | Read data word |
| intrq | output | 1 | Level interrupt request |

## Verification
The bench builds the block with BLK_AW=2, giving a four-block store, and the full 2048-byte block. With a store this small, a three-block read starting near the top of the store wraps around its index, and every word of every block can be compared against the arithmetic rule.

The bench sweeps block counts 0, 1 and 3 against caps of 0, an odd value, a value that splits a block unevenly, a multiple of the block size and the maximum. This reaches the minimum-size burst, the even rounding, and a short final burst. An unsupported opcode, an ignored command byte and a stalled output stream are each driven once.

// File: rtl/atapi_seq_pkg.sv
package atapi_seq_pkg;
  localparam logic [7:0] OPC_PACKET = 8'hA0;
  localparam logic [7:0] OPC_READ10 = 8'h28;

  localparam int SB_BSY  = 7;
  localparam int SB_DRDY = 6;
  localparam int SB_DF   = 5;
  localparam int SB_DRQ  = 3;
  localparam int SB_ERR  = 0;

  localparam logic [2:0] RA_CNT_LO   = 3'd4;
  localparam logic [2:0] RA_CNT_HI   = 3'd5;
  localparam logic [2:0] RA_CMD_STAT = 3'd7;

  localparam int PKT_WORDS = 6;
  localparam int PKT_BYTES = 2 * PKT_WORDS;

  typedef enum logic [2:0] {
    S_IDLE,
    S_CMDPKT,
    S_DECODE,
    S_SETUP,
    S_XFER
  } seq_state_t;

  typedef struct packed {
    logic [7:0]  opcode;
    logic [31:0] lba;
    logic [15:0] nblk;
  } rd10_cmd_t;
endpackage

// File: rtl/atapi_pkt_collect.sv
module atapi_pkt_collect
  import atapi_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clear,
  input  logic        push,
  input  logic [15:0] word,
  output logic        full,
  output rd10_cmd_t   cmd
);
  localparam int CNT_W = $clog2(PKT_WORDS + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [15:0]      wq [PKT_WORDS];
  logic [7:0]       pb [PKT_BYTES];

  assign full = (cnt_q == CNT_W'(PKT_WORDS));

  always_ff @(posedge clk) begin
    if (!rst_n || clear) cnt_q <= '0;
    else if (push)       cnt_q <= cnt_q + 1'b1;
  end

  for (genvar g = 0; g < PKT_WORDS; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)                               wq[g] <= '0;
      else if (push && cnt_q == CNT_W'(g))      wq[g] <= word;
    end
  end

  always_comb begin
    for (int i = 0; i < PKT_WORDS; i++) begin
      pb[2*i]   = wq[i][7:0];
      pb[2*i+1] = wq[i][15:8];
    end
    cmd.opcode = pb[0];
    cmd.lba    = {pb[2], pb[3], pb[4], pb[5]};
    cmd.nblk   = {pb[7], pb[8]};
  end

  AST_PKT_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full); // R3
endmodule

// File: rtl/atapi_burst_ctr.sv
module atapi_burst_ctr #(
  parameter int BLK_WORDS = 1024,
  parameter int CNT_W     = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] nblk,
  input  logic [15:0]      limit_bytes,
  input  logic             start,
  input  logic             pop,
  output logic [15:0]      next_bytes,
  output logic             burst_last,
  output logic             rem_last
);
  localparam int WIDX_W = $clog2(BLK_WORDS);
  localparam int REM_W  = CNT_W + WIDX_W;

  logic [REM_W-1:0] rem_q;
  logic [15:0]      burst_q;
  logic [15:0]      limit_words;
  logic [15:0]      next_words;

  assign limit_words = {1'b0, limit_bytes[15:1]};

  always_comb begin
    if ({{(REM_W-16){1'b0}}, limit_words} < rem_q) next_words = limit_words;
    else                                           next_words = rem_q[15:0];
  end

  assign next_bytes = {next_words[14:0], 1'b0};
  assign burst_last = (burst_q == 16'd1);
  assign rem_last   = (rem_q == REM_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem_q   <= '0;
      burst_q <= '0;
    end else begin
      if (load)       rem_q <= {nblk, {WIDX_W{1'b0}}};
      else if (pop)   rem_q <= rem_q - 1'b1;
      if (start)      burst_q <= next_words;
      else if (pop)   burst_q <= burst_q - 1'b1;
    end
  end

  AST_BURST_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (burst_q != 16'd0) && (burst_q <= $past(limit_words))); // R6
endmodule

// File: rtl/atapi_blk_pattern.sv
module atapi_blk_pattern #(
  parameter int BLK_AW    = 2,
  parameter int BLK_WORDS = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BLK_AW-1:0] blk_start,
  input  logic              advance,
  output logic [15:0]       word
);
  localparam int WIDX_W = $clog2(BLK_WORDS);
  localparam int PAD_W  = 16 - WIDX_W - BLK_AW;

  logic [BLK_AW-1:0] blk_q;
  logic [WIDX_W-1:0] widx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      blk_q  <= '0;
      widx_q <= '0;
    end else if (load) begin
      blk_q  <= blk_start;
      widx_q <= '0;
    end else if (advance) begin
      widx_q <= widx_q + 1'b1;
      if (&widx_q) blk_q <= blk_q + 1'b1;
    end
  end

  assign word = {{PAD_W{1'b0}}, blk_q, widx_q};
endmodule

// File: rtl/atapi_intr_ctl.sv
module atapi_intr_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic intrq
);
  always_ff @(posedge clk) begin
    if (!rst_n)   intrq <= 1'b0;
    else if (set) intrq <= 1'b1;
    else if (clr) intrq <= 1'b0;
  end

  AST_INTR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> !intrq); // R8
endmodule

// File: rtl/atapi_pio_seq.sv
module atapi_pio_seq
  import atapi_seq_pkg::*;
#(
  parameter int BLK_AW      = 2,
  parameter int BLOCK_BYTES = 2048
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [2:0]  reg_addr,
  input  logic [7:0]  reg_wdata,
  output logic [7:0]  reg_rdata,
  input  logic        pkt_valid,
  output logic        pkt_ready,
  input  logic [15:0] pkt_data,
  output logic        dout_valid,
  input  logic        dout_ready,
  output logic [15:0] dout_data,
  output logic        intrq
);
  localparam int BLK_WORDS = BLOCK_BYTES / 2;

  seq_state_t state_q;
  logic [7:0]  cnt_lo_q, cnt_hi_q;
  logic [15:0] limit_q;
  logic        err_q;

  logic        pkt_full, pkt_push, pkt_accept;
  rd10_cmd_t   cmd;
  logic        cmd_bad, cmd_zero, cmd_go;
  logic [15:0] raw_limit, even_limit, next_bytes;
  logic        burst_last, rem_last, pop;
  logic        bsy, drq, intr_set, stat_rd;
  logic [7:0]  status;

  assign raw_limit  = {cnt_hi_q, cnt_lo_q};
  assign even_limit = (raw_limit < 16'd2) ? 16'd2 : {raw_limit[15:1], 1'b0};

  assign pkt_accept = reg_wr && (reg_addr == RA_CMD_STAT) &&
                      (state_q == S_IDLE) && (reg_wdata == OPC_PACKET);
  assign pkt_ready  = (state_q == S_CMDPKT) && !pkt_full;
  assign pkt_push   = pkt_valid && pkt_ready;

  assign cmd_bad  = (cmd.opcode != OPC_READ10);
  assign cmd_zero = (cmd.nblk == 16'd0);
  assign cmd_go   = (state_q == S_DECODE) && !cmd_bad && !cmd_zero;

  assign dout_valid = (state_q == S_XFER);
  assign pop        = dout_valid && dout_ready;

  atapi_pkt_collect u_pkt (
    .clk(clk), .rst_n(rst_n), .clear(pkt_accept), .push(pkt_push),
    .word(pkt_data), .full(pkt_full), .cmd(cmd)
  );

  atapi_burst_ctr #(.BLK_WORDS(BLK_WORDS), .CNT_W(16)) u_ctr (
    .clk(clk), .rst_n(rst_n), .load(cmd_go), .nblk(cmd.nblk),
    .limit_bytes(limit_q), .start(state_q == S_SETUP), .pop(pop),
    .next_bytes(next_bytes), .burst_last(burst_last), .rem_last(rem_last)
  );

  atapi_blk_pattern #(.BLK_AW(BLK_AW), .BLK_WORDS(BLK_WORDS)) u_store (
    .clk(clk), .rst_n(rst_n), .load(cmd_go), .blk_start(cmd.lba[BLK_AW-1:0]),
    .advance(pop), .word(dout_data)
  );

  assign intr_set = ((state_q == S_DECODE) && (cmd_bad || cmd_zero)) ||
                    (state_q == S_SETUP) ||
                    (pop && burst_last && rem_last);
  assign stat_rd  = reg_rd && (reg_addr == RA_CMD_STAT);

  atapi_intr_ctl u_intr (
    .clk(clk), .rst_n(rst_n), .set(intr_set), .clr(stat_rd), .intrq(intrq)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      cnt_lo_q <= '0;
      cnt_hi_q <= '0;
      limit_q  <= 16'd2;
      err_q    <= 1'b0;
    end else begin
      unique case (state_q)
        S_IDLE: begin
          if (reg_wr && reg_addr == RA_CNT_LO) cnt_lo_q <= reg_wdata;
          if (reg_wr && reg_addr == RA_CNT_HI) cnt_hi_q <= reg_wdata;
          if (pkt_accept) begin
            limit_q <= even_limit;
            err_q   <= 1'b0;
            state_q <= S_CMDPKT;
          end
        end
        S_CMDPKT: if (pkt_full) state_q <= S_DECODE;
        S_DECODE: begin
          if (cmd_bad) begin
            err_q   <= 1'b1;
            state_q <= S_IDLE;
          end else if (cmd_zero) begin
            state_q <= S_IDLE;
          end else begin
            state_q <= S_SETUP;
          end
        end
        S_SETUP: begin
          cnt_lo_q <= next_bytes[7:0];
          cnt_hi_q <= next_bytes[15:8];
          state_q  <= S_XFER;
        end
        S_XFER: if (pop && burst_last) state_q <= rem_last ? S_IDLE : S_SETUP;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign bsy = ((state_q == S_CMDPKT) && pkt_full) ||
               (state_q == S_DECODE) || (state_q == S_SETUP);
  assign drq = pkt_ready || dout_valid;

  always_comb begin
    status          = '0;
    status[SB_BSY]  = bsy;
    status[SB_DRDY] = 1'b1;
    status[SB_DF]   = 1'b0;
    status[SB_DRQ]  = drq;
    status[SB_ERR]  = err_q;
  end

  always_comb begin
    unique case (reg_addr)
      RA_CNT_LO:   reg_rdata = cnt_lo_q;
      RA_CNT_HI:   reg_rdata = cnt_hi_q;
      RA_CMD_STAT: reg_rdata = status;
      default:     reg_rdata = 8'h00;
    endcase
  end

  AST_BSY_DRQ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(bsy && drq)); // R13
  AST_DOUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_valid && !dout_ready) |=> (dout_valid && $stable(dout_data))); // R12
  AST_ERR_NO_DRQ: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> !drq); // R11
  AST_LIMIT_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (limit_q[0] == 1'b0) && (limit_q != 16'd0)); // R5
endmodule

// File: tb/atapi_pio_seq_test.sv
`timescale 1ns/1ps
module atapi_pio_seq_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        pkt_valid = 1'b0, pkt_ready;
  logic [15:0] pkt_data = '0;
  logic        dout_valid, dout_ready = 1'b0;
  logic [15:0] dout_data;
  logic        intrq;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  atapi_pio_seq #(.BLK_AW(2), .BLOCK_BYTES(2048)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pkt_valid(pkt_valid), .pkt_ready(pkt_ready), .pkt_data(pkt_data),
    .dout_valid(dout_valid), .dout_ready(dout_ready), .dout_data(dout_data),
    .intrq(intrq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic send_word(input logic [15:0] w);
    pkt_data  = w;
    pkt_valid = 1'b1;
    for (int i = 0; i < 50 && !pkt_ready; i++) @(negedge clk);
    @(negedge clk);
    pkt_valid = 1'b0;
  endtask

  task automatic wait_intr(input string req);
    int n = 0;
    while (!intrq && n < 60) begin @(negedge clk); n++; end
    chk(intrq, req, intrq, 1);
  endtask

  function automatic logic [15:0] exp_word(input logic [31:0] lba, input int k);
    int blk;
    blk = (int'(lba % 4) + k / 1024) % 4;
    return 16'(blk * 1024 + k % 1024);
  endfunction

  task automatic send_packet(input logic [7:0] opc, input logic [31:0] lba,
                             input logic [15:0] nblk);
    logic [7:0] s;
    wr(3'd7, 8'hA0);
    @(negedge clk);
    rd(3'd7, s);
    chk(s == 8'h48, "R2 status after packet command", s, 8'h48);
    chk(intrq == 1'b0, "R2 no interrupt on accept", intrq, 0);
    @(negedge clk);
    send_word({8'h00, opc});
    send_word({lba[23:16], lba[31:24]});
    send_word({lba[7:0], lba[15:8]});
    send_word({nblk[15:8], 8'h00});
    send_word({8'h00, nblk[7:0]});
    send_word(16'h0000);
    chk(pkt_ready == 1'b0, "R3 ready low after six words", pkt_ready, 0);
    rd(3'd7, s);
    chk(s == 8'hC0, "R13 busy after packet", s, 8'hC0);
  endtask

  task automatic run_read(input logic [15:0] lim, input logic [31:0] lba,
                          input logic [15:0] nblk, input bit stall);
    logic [7:0] s, lo, hi;
    int exp_lim, remaining, b, k, bad, bad_a, bad_e;
    wr(3'd4, lim[7:0]);
    wr(3'd5, lim[15:8]);
    send_packet(8'h28, lba, nblk);
    exp_lim   = (lim < 2) ? 2 : (int'(lim) & ~1);
    remaining = int'(nblk) * 2048;
    k = 0;
    while (remaining > 0) begin
      wait_intr("R7 interrupt before burst");
      b = (exp_lim < remaining) ? exp_lim : remaining;
      rd(3'd4, lo);
      rd(3'd5, hi);
      chk({hi, lo} == 16'(b), "R6 R5 burst byte count", {hi, lo}, b);
      rd(3'd7, s);
      chk(s == 8'h48, "R7 status before burst", s, 8'h48);
      chk(intrq == 1'b0, "R8 status read clears interrupt", intrq, 0);
      if (stall && k == 0) begin
        logic [15:0] held;
        held = dout_data;
        repeat (3) @(negedge clk);
        chk(dout_valid && dout_data == held, "R12 data held under stall", dout_data, held);
      end
      bad = 0; bad_a = 0; bad_e = 0;
      for (int w = 0; w < b / 2; w++) begin
        for (int t = 0; t < 50 && !dout_valid; t++) @(negedge clk);
        if (!dout_valid || dout_data != exp_word(lba, k)) begin
          if (bad == 0) begin bad_a = dout_data; bad_e = exp_word(lba, k); end
          bad++;
        end
        dout_ready = 1'b1;
        @(negedge clk);
        dout_ready = 1'b0;
        k++;
      end
      chk(bad == 0, "R4 burst data words", bad_a, bad_e);
      remaining -= b;
    end
    wait_intr(nblk == 0 ? "R10 completion on zero count" : "R9 completion interrupt");
    rd(3'd7, s);
    chk(s == 8'h40, nblk == 0 ? "R10 final status" : "R9 final status", s, 8'h40);
    chk(intrq == 1'b0 && dout_valid == 1'b0, "R9 idle after completion",
        {intrq, dout_valid}, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] s, lo;
    logic [15:0] lims [5];
    logic [15:0] cnts [3];
    lims[0] = 16'h0000; lims[1] = 16'h0FFF; lims[2] = 16'h0801;
    lims[3] = 16'h1400; lims[4] = 16'hFFFF;
    cnts[0] = 16'd0; cnts[1] = 16'd1; cnts[2] = 16'd3;

    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(reg_rdata == 8'h40 || reg_addr != 3'd7, "R1 reset status", reg_rdata, 8'h40);
    rd(3'd7, s);
    chk(s == 8'h40, "R1 reset status", s, 8'h40);
    chk(!intrq && !pkt_ready && !dout_valid, "R1 reset outputs",
        {intrq, pkt_ready, dout_valid}, 0);

    // R2: an unknown command byte changes nothing
    wr(3'd4, 8'h34);
    wr(3'd7, 8'hEC);
    repeat (3) @(negedge clk);
    rd(3'd7, s);
    chk(s == 8'h40, "R2 ignored command status", s, 8'h40);
    chk(!intrq && !pkt_ready, "R2 ignored command outputs", {intrq, pkt_ready}, 0);
    rd(3'd4, lo);
    chk(lo == 8'h34, "R2 byte count untouched", lo, 8'h34);

    // R11: unsupported opcode, then recovery through a zero-count read (R10)
    wr(3'd5, 8'h00);
    send_packet(8'h43, 32'h0, 16'd5);
    wait_intr("R11 completion interrupt on bad opcode");
    rd(3'd7, s);
    chk(s == 8'h41, "R11 error status", s, 8'h41);
    chk(!intrq && !pkt_ready, "R11 no data request", {intrq, pkt_ready}, 0);
    run_read(16'h0200, 32'h0, 16'd0, 1'b0);

    // sweep of caps and block counts
    foreach (lims[i]) begin
      foreach (cnts[j]) begin
        if (!(lims[i] < 2 && cnts[j] > 1))
          run_read(lims[i], (cnts[j] == 3) ? 32'h0000_0102 : 32'hFFFF_FFFF,
                   cnts[j], (i == 1 && j == 1));
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule